// File: doc/BRIEF.md
# Floating-Point Register Rename Stage (Load-Target Allocation)

This block renames one instruction per cycle for a floating-point register file that has 32 logical and 40 physical registers. Each instruction is arithmetic, load or store and carries a 5-bit target field and two 5-bit source fields. The block translates all three fields into 6-bit physical names and passes the renamed instruction to the next stage through a registered output slot. Only a load changes the mapping. Its target receives a fresh physical name taken from the head of a free-name FIFO. The name it supersedes is not freed straight away: it waits in a pending-return FIFO.

A superseded name goes back to the free list only when the surrounding pipeline raises `free_return`. That pulse means the last arithmetic instruction or store that could still read the name has been performed. Each pulse moves one name from the head of the pending FIFO to the tail of the free FIFO. Because the unit never creates or drops names, the two FIFOs together always hold exactly the 8 spare names.

Both data paths use valid/ready. An instruction is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while the output slot holds an instruction the consumer has not taken. It is also low while a load is presented and the free FIFO is empty. The output slot keeps its contents unchanged until `out_ready` is seen high.

Top module: `rename_core`

## Requirements
- R1: Out of reset, logical register i translates to physical register i for every field. At reset `out_valid` is 0 and `in_ready` is 1.
- R2: Out of reset the free FIFO holds physical names 32 through 39 with 32 at its head, so successive loads receive 32, 33, 34 and so on in that order.
- R3: An instruction whose op code is not load (00 arithmetic, 10 store, 11 treated as arithmetic) translates its target and sources through the current mapping and changes no mapping.
- R4: A load (op code 01) reports the free FIFO head as its physical target. From the next accepted instruction onward, its logical target translates to that name.
- R5: A load's own source fields are translated with the mapping as it stood before that load's target update.
- R6: While the free FIFO is empty, `in_ready` is low whenever a load is presented. An arithmetic or store instruction is still accepted.
- R7: Each cycle with `free_return` high and the pending FIFO non-empty moves the oldest superseded name to the free FIFO tail. Superseded names therefore come back to loads in the order the loads displaced them.
- R8: `free_return` has no effect while the pending FIFO is empty: no name is added to the free FIFO.
- R9: A renamed instruction appears on the output one cycle after acceptance. While `out_valid` is high and `out_ready` is low, the output holds steady and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Stage can take the presented instruction |
| in_op | input | 2 | 00 arithmetic, 01 load, 10 store, 11 as arithmetic |
| in_dst | input | 5 | Logical target register |
| in_src_a | input | 5 | Logical first source register |
| in_src_b | input | 5 | Logical second source register |
| free_return | input | 1 | Move one pending name back to the free FIFO |
| out_valid | output | 1 | Renamed instruction present |
| out_ready | input | 1 | Consumer takes the renamed instruction |
| out_op | output | 2 | Op code passed through |
| out_dst | output | 6 | Physical target |
| out_src_a | output | 6 | Physical first source |
| out_src_b | output | 6 | Physical second source |

## Verification
An accepted instruction is captured into the output slot on the same rising edge that accepts it. The bench therefore drives at a falling edge, waits for the accepting rising edge, and reads the renamed fields at the next falling edge.

A mapping change made by a load is visible to the very next accepted instruction. A `free_return` pulse makes its name available to a load presented on the following cycle. `in_ready` is combinational from the presented op code and the stage state, so stall checks read it at a falling edge while the load is still presented. Back-pressure checks hold `out_ready` low across several edges and confirm that the slot and `in_ready` stay unchanged.

// File: rtl/rename_pkg.sv
`timescale 1ns/1ps
package rename_pkg;
  localparam int unsigned LOG_REGS  = 32;
  localparam int unsigned PHYS_REGS = 40;

  typedef enum logic [1:0] {
    OP_ARITH = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_OTHER = 2'b11
  } rn_op_e;
endpackage

// File: rtl/name_fifo.sv
`timescale 1ns/1ps
module name_fifo #(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned W         = 6,
  parameter bit          INIT_FULL = 1'b0,
  parameter int unsigned INIT_BASE = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign count   = cnt;
  assign head    = mem[rd_ptr];
  assign do_pop  = pop && !empty;
  assign do_push = push && (cnt != CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= INIT_FULL ? CNT_W'(DEPTH) : '0;
      for (int k = 0; k < DEPTH; k++)
        mem[k] <= INIT_FULL ? W'(INIT_BASE + k) : '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (do_pop)
        rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/remap_table.sv
`timescale 1ns/1ps
module remap_table #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_dst,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  output logic [DW-1:0] map_dst,
  output logic [DW-1:0] map_a,
  output logic [DW-1:0] map_b,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] tbl [ENTRIES];

  // Reads see the table before this cycle's write lands.
  assign map_dst = tbl[rd_dst];
  assign map_a   = tbl[rd_a];
  assign map_b   = tbl[rd_b];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[e] <= DW'(e);
      else if (we && wr_addr == AW'(e))
        tbl[e] <= wr_data;
    end
  end
endmodule

// File: rtl/rename_core.sv
`timescale 1ns/1ps
module rename_core
  import rename_pkg::*;
#(
  parameter int unsigned N_LOG  = LOG_REGS,
  parameter int unsigned N_PHYS = PHYS_REGS,
  parameter int unsigned LW     = $clog2(N_LOG),
  parameter int unsigned PW     = $clog2(N_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [LW-1:0] in_dst,
  input  logic [LW-1:0] in_src_a,
  input  logic [LW-1:0] in_src_b,
  input  logic          free_return,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_op,
  output logic [PW-1:0] out_dst,
  output logic [PW-1:0] out_src_a,
  output logic [PW-1:0] out_src_b
);
  localparam int unsigned SPARE = N_PHYS - N_LOG;
  localparam int unsigned CW    = $clog2(SPARE+1);

  logic          is_load, slot_free, fire, alloc, recycle;
  logic [PW-1:0] map_dst, map_a, map_b;
  logic [PW-1:0] fl_head, pq_head;
  logic          fl_empty, pq_empty;
  logic [CW-1:0] fl_count, pq_count;

  assign is_load   = (rn_op_e'(in_op) == OP_LOAD);
  assign slot_free = !out_valid || out_ready;
  assign in_ready  = slot_free && !(is_load && fl_empty);
  assign fire      = in_valid && in_ready;
  assign alloc     = fire && is_load;
  assign recycle   = free_return && !pq_empty;

  remap_table #(.ENTRIES(N_LOG), .AW(LW), .DW(PW)) map_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_dst  (in_dst),
    .rd_a    (in_src_a),
    .rd_b    (in_src_b),
    .map_dst (map_dst),
    .map_a   (map_a),
    .map_b   (map_b),
    .we      (alloc),
    .wr_addr (in_dst),
    .wr_data (fl_head)
  );

  name_fifo #(.DEPTH(SPARE), .W(PW), .INIT_FULL(1'b1), .INIT_BASE(N_LOG)) free_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (recycle),
    .push_data (pq_head),
    .pop       (alloc),
    .head      (fl_head),
    .empty     (fl_empty),
    .count     (fl_count)
  );

  name_fifo #(.DEPTH(SPARE), .W(PW), .INIT_FULL(1'b0), .INIT_BASE(0)) pend_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (alloc),
    .push_data (map_dst),
    .pop       (recycle),
    .head      (pq_head),
    .empty     (pq_empty),
    .count     (pq_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_op    <= '0;
      out_dst   <= '0;
      out_src_a <= '0;
      out_src_b <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_op    <= in_op;
      out_dst   <= alloc ? fl_head : map_dst;
      out_src_a <= map_a;
      out_src_b <= map_b;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rename_core_chk.sv
`timescale 1ns/1ps
module rename_core_chk #(
  parameter int unsigned PW    = 6,
  parameter int unsigned CW    = 4,
  parameter int unsigned SPARE = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_op,
  input logic          free_return,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_dst,
  input logic [PW-1:0] out_src_a,
  input logic [PW-1:0] out_src_b,
  input logic [PW-1:0] fl_head,
  input logic          fl_empty,
  input logic          pq_empty,
  input logic [CW-1:0] fl_count,
  input logic [CW-1:0] pq_count
);
  // R6
  load_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_empty && in_op == 2'b01) |-> !in_ready);

  // R9
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dst)
                                   && $stable(out_src_a) && $stable(out_src_b)));

  // R4
  load_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b01) |=> (out_valid && out_dst == $past(fl_head)));

  // R8
  idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_return && pq_empty && !(in_valid && in_ready && in_op == 2'b01))
      |=> fl_count == $past(fl_count));

  // R7
  always @(posedge clk) begin
    if (rst_n) begin
      name_conserve_chk: assert (32'(fl_count) + 32'(pq_count) == SPARE);
    end
  end
endmodule

bind rename_core rename_core_chk #(.PW(PW), .CW(CW), .SPARE(SPARE)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .free_return (free_return),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_dst     (out_dst),
  .out_src_a   (out_src_a),
  .out_src_b   (out_src_b),
  .fl_head     (fl_head),
  .fl_empty    (fl_empty),
  .pq_empty    (pq_empty),
  .fl_count    (fl_count),
  .pq_count    (pq_count)
);

// File: tb/rename_core_tb.sv
`timescale 1ns/1ps
module rename_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_op = 2'b00;
  logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic       free_return = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [1:0] out_op;
  logic [5:0] out_dst, out_src_a, out_src_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  rename_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .free_return(free_return), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_dst(out_dst), .out_src_a(out_src_a), .out_src_b(out_src_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one instruction, wait for acceptance, return the renamed fields.
  task automatic issue(input logic [1:0] op, input logic [4:0] d, a, b,
                       output int pd, output int pa, output int pb);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_dst = d; in_src_a = a; in_src_b = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    pd = out_dst; pa = out_src_a; pb = out_src_b;
  endtask

  task automatic pulse_return();
    @(negedge clk);
    free_return = 1'b1;
    @(negedge clk);
    free_return = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid at reset", out_valid, 0);
    chk("R1 in_ready at reset", in_ready, 1);
  endtask

  task automatic t_identity();
    int d, a, b;
    issue(2'b00, 5'd5, 5'd9, 5'd31, d, a, b);
    chk("R1 dst", d, 5); chk("R1 src_a", a, 9); chk("R1 src_b", b, 31);
  endtask

  task automatic t_idle_return();
    // R8: pending FIFO empty, pulse must add nothing to the free FIFO
    pulse_return();
  endtask

  task automatic t_load_chain();
    int d, a, b;
    issue(2'b01, 5'd3, 5'd1, 5'd2, d, a, b);
    chk("R2 first load gets 32", d, 32);
    chk("R4 load dst 32", d, 32);
    issue(2'b00, 5'd7, 5'd3, 5'd3, d, a, b);
    chk("R4 src sees new map", a, 32);
    issue(2'b00, 5'd3, 5'd4, 5'd4, d, a, b);
    chk("R3 arith dst via map", d, 32);
    issue(2'b10, 5'd3, 5'd3, 5'd0, d, a, b);
    chk("R3 store keeps map", a, 32);
    chk("R3 store dst", d, 32);
    issue(2'b01, 5'd3, 5'd3, 5'd3, d, a, b);
    chk("R5 load src uses old map", a, 32);
    chk("R2 second load gets 33", d, 33);
    for (int r = 0; r < 6; r++) begin
      issue(2'b01, 5'(r), 5'd20, 5'd21, d, a, b);
      chk("R2 load order", d, 34 + r);
    end
  endtask

  task automatic t_empty_stall();
    int d, a, b;
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b01; in_dst = 5'd9;
    repeat (3) @(negedge clk);
    chk("R6 load stalled when empty", in_ready, 0);
    chk("R8 nothing extra freed", out_valid, 0);
    in_valid = 1'b0;
    issue(2'b00, 5'd6, 5'd3, 5'd0, d, a, b);
    chk("R6 arith passes when empty", d, 6);
    chk("R4 latest map of r3", a, 37);
  endtask

  task automatic t_recycle();
    int d, a, b;
    pulse_return();
    issue(2'b01, 5'd10, 5'd0, 5'd0, d, a, b);
    chk("R7 first recycled name", d, 3);
    pulse_return();
    pulse_return();
    issue(2'b01, 5'd11, 5'd0, 5'd0, d, a, b);
    chk("R7 second recycled name", d, 32);
    issue(2'b01, 5'd12, 5'd0, 5'd0, d, a, b);
    chk("R7 third recycled name", d, 0);
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b01; in_dst = 5'd13;
    @(negedge clk);
    chk("R6 empty again after recycled names", in_ready, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b00; in_dst = 5'd20; in_src_a = 5'd10; in_src_b = 5'd11;
    @(posedge clk);
    @(negedge clk);
    chk("R9 one-cycle latency", out_valid, 1);
    chk("R9 out dst", out_dst, 20);
    in_dst = 5'd21;
    chk("R9 in_ready low while held", in_ready, 0);
    repeat (2) @(negedge clk);
    chk("R9 output held", out_dst, 20);
    chk("R9 src held", out_src_a, 3);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next after release", out_dst, 21);
    @(negedge clk);
    chk("R9 slot drains", out_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_identity();
    t_idle_return();
    t_load_chain();
    t_empty_stall();
    t_recycle();
    t_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule